// File: doc/BRIEF.md
# DMA Width-Converting Transfer Engine

This block is the data path and address generator of a single DMA channel. It moves a programmed number of items from a source port (peripheral side) to a destination port (memory side), and the two sides may use different data widths. Source items are fetched at the source width and collected in a small byte buffer. Destination words are written at the destination width. Narrow items are packed into wider words and wide items are split into narrower pieces, in both cases little-endian.

Software-side logic sets the configuration inputs and pulses `start`. The engine captures the whole configuration at that edge. It then runs source reads and destination writes over simple request/valid and request/ack handshakes, and ends the job with a one-cycle `done` pulse. Each side's address can be held fixed or stepped. A word-step option moves the source address by 4 bytes per read whatever the source width.

Top module: `dma_wconv_engine`

## Requirements
- R1: Width codes are 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes on both sides. `src_size` and `dst_size` show the captured code of their side while a request is raised.
- R2: `cfg_items` counts source items. Exactly that many source reads occur, and exactly ceil(items × source bytes / destination bytes) destination writes.
- R3: When packing (source narrower than destination), earlier items fill the lower bytes of a word. A write is raised only once a full destination word has been collected, except for the final word.
- R4: When unpacking (source wider than destination), an item is written as pieces from its low byte upward. No new source read is raised until every byte already read has been written.
- R5: With equal widths, each item is written unchanged as one destination word.
- R6: With the source increment enabled, the source address steps by the source width after each read, or by 4 when word-step is set. With it disabled, every read uses the base address.
- R7: With the destination increment enabled, the destination address steps by the destination width after each write. With it disabled, every write uses the base address.
- R8: A final partial word carries zeros in its unused upper bytes. Bits of `dst_data` above the destination width are always zero.
- R9: `done` is high for exactly one cycle, the cycle after the final write is acknowledged, and `busy` is low from the next cycle. A job of zero items raises `done` with no reads or writes.
- R10: A request stays high with stable address (and data, for writes) until its valid/ack. Source and destination requests are never high together, and neither is high while idle.
- R11: `start` is ignored while busy, and changes to the configuration inputs after the start edge do not affect the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job; configuration captured on this edge |
| cfg_src_wid | input | 2 | Source width code |
| cfg_dst_wid | input | 2 | Destination width code |
| cfg_src_inc | input | 1 | Source address increment enable |
| cfg_dst_inc | input | 1 | Destination address increment enable |
| cfg_src_step4 | input | 1 | Source address steps by 4 per read |
| cfg_items | input | CW | Number of source items |
| cfg_src_base | input | AW | First source address |
| cfg_dst_base | input | AW | First destination address |
| src_req | output | 1 | Source read request |
| src_addr | output | AW | Source read address |
| src_size | output | 2 | Source read width code |
| src_valid | input | 1 | Read data present; completes the read |
| src_data | input | DW | Read data, item in the low bytes |
| dst_req | output | 1 | Destination write request |
| dst_addr | output | AW | Destination write address |
| dst_size | output | 2 | Destination write width code |
| dst_data | output | DW | Write data, zero above the width |
| dst_ack | input | 1 | Write accepted |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job completion pulse |

## Verification
After the start edge, the first request rises two edges later, because one decision cycle follows the capture. Every later request rises in the cycle after the previous handshake. Read data is taken on the edge where `src_valid` is high. A new write's data already reflects that edge's push when the write request rises one cycle later. `done` rises on the edge after the final acknowledging edge. The bench drives responses and samples every output on the falling clock edge, one half-period clear of the updating edge. It checks each handshake at the moment it grants it and checks `done` exactly one falling edge after granting the last acknowledge.

// File: rtl/dma_wconv_pkg.sv
package dma_wconv_pkg;

   typedef enum logic [1:0] {
      WID_B8  = 2'b00,
      WID_B16 = 2'b01,
      WID_B32 = 2'b10
   } wid_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_FIN
   } seq_state_e;

   // reserved code 11 folds onto the widest legal width
   function automatic wid_e wid_norm(input logic [1:0] code);
      return (code == 2'b11) ? WID_B32 : wid_e'(code);
   endfunction

   function automatic logic [2:0] wid_bytes(input wid_e w);
      case (w)
         WID_B8:  return 3'd1;
         WID_B16: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/dma_wconv_addr_gen.sv
module dma_wconv_addr_gen #(
   parameter int AW            = 32,
   parameter bit WORD_STEP_OK  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          inc_en,
   input  logic          word_step,
   input  logic [2:0]    unit_bytes,
   input  logic          advance,
   output logic [AW-1:0] addr
);

   logic [2:0]    step;
   logic [AW-1:0] addr_q;

   generate
      if (WORD_STEP_OK) begin : g_word_step
         assign step = word_step ? 3'd4 : unit_bytes;
      end else begin : g_unit_step
         logic unused_word_step;
         assign unused_word_step = word_step;
         assign step = unit_bytes;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= base;
      end else if (advance && inc_en) begin
         addr_q <= addr_q + AW'(step);
      end
   end

   assign addr = addr_q;

endmodule

// File: rtl/dma_wconv_pack_buf.sv
module dma_wconv_pack_buf #(
   parameter  int DW = 32,
   localparam int NB = DW / 8,
   localparam int FW = $clog2(NB) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic [FW-1:0] push_bytes,
   input  logic          pop,
   input  logic [FW-1:0] pop_bytes,
   output logic [FW-1:0] fill,
   output logic [DW-1:0] head
);

   logic [DW-1:0] store_q;
   logic [FW-1:0] fill_q;
   logic [DW-1:0] in_mask;
   logic [DW-1:0] out_mask;
   logic [DW-1:0] in_shift;

   always_comb begin
      for (int b = 0; b < NB; b++) begin
         in_mask[b*8 +: 8]  = (b < int'(push_bytes)) ? 8'hFF : 8'h00;
         out_mask[b*8 +: 8] = (b < int'(pop_bytes))  ? 8'hFF : 8'h00;
      end
      in_shift = (push_data & in_mask) << {fill_q, 3'b000};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= '0;
         fill_q  <= '0;
      end else if (clear) begin
         store_q <= '0;
         fill_q  <= '0;
      end else if (push) begin
         store_q <= store_q | in_shift;
         fill_q  <= fill_q + push_bytes;
      end else if (pop) begin
         store_q <= store_q >> {pop_bytes, 3'b000};
         fill_q  <= (fill_q > pop_bytes) ? (fill_q - pop_bytes) : '0;
      end
   end

   assign fill = fill_q;
   assign head = store_q & out_mask;

endmodule

// File: rtl/dma_wconv_seq.sv
module dma_wconv_seq
   import dma_wconv_pkg::*;
#(
   parameter int CW = 16,
   parameter int FW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] items,
   input  logic [FW-1:0] fill,
   input  logic [FW-1:0] word_bytes,
   input  logic          rd_valid,
   input  logic          wr_ack,
   output logic          load,
   output logic          rd_req,
   output logic          wr_req,
   output logic          push,
   output logic          pop,
   output logic          busy,
   output logic          done
);

   seq_state_e    state_q;
   logic [CW-1:0] left_q;
   logic          rd_q;
   logic          wr_q;
   logic          word_ready;
   logic          flush;
   logic          last_pop;

   assign word_ready = (fill >= word_bytes);
   assign flush      = (left_q == '0) && (fill != '0);
   assign load       = (state_q == ST_IDLE) && start;
   assign push       = rd_q && rd_valid;
   assign pop        = wr_q && wr_ack;
   assign last_pop   = pop && (left_q == '0) && (fill <= word_bytes);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
         rd_q    <= 1'b0;
         wr_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  left_q  <= items;
                  rd_q    <= 1'b0;
                  wr_q    <= 1'b0;
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (rd_q) begin
                  if (rd_valid) begin
                     rd_q   <= 1'b0;
                     left_q <= left_q - 1'b1;
                  end
               end else if (wr_q) begin
                  if (wr_ack) begin
                     wr_q <= 1'b0;
                     if (last_pop) state_q <= ST_FIN;
                  end
               end else if (word_ready || flush) begin
                  wr_q <= 1'b1;
               end else if (left_q != '0) begin
                  rd_q <= 1'b1;
               end else begin
                  state_q <= ST_FIN;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_req = rd_q;
   assign wr_req = wr_q;
   assign busy   = (state_q != ST_IDLE);
   assign done   = (state_q == ST_FIN);

endmodule

// File: rtl/dma_wconv_engine.sv
module dma_wconv_engine
   import dma_wconv_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    cfg_src_wid,
   input  logic [1:0]    cfg_dst_wid,
   input  logic          cfg_src_inc,
   input  logic          cfg_dst_inc,
   input  logic          cfg_src_step4,
   input  logic [CW-1:0] cfg_items,
   input  logic [AW-1:0] cfg_src_base,
   input  logic [AW-1:0] cfg_dst_base,
   output logic          src_req,
   output logic [AW-1:0] src_addr,
   output logic [1:0]    src_size,
   input  logic          src_valid,
   input  logic [DW-1:0] src_data,
   output logic          dst_req,
   output logic [AW-1:0] dst_addr,
   output logic [1:0]    dst_size,
   output logic [DW-1:0] dst_data,
   input  logic          dst_ack,
   output logic          busy,
   output logic          done
);

   localparam int NB = DW / 8;
   localparam int FW = $clog2(NB) + 1;

   generate
      if (!(DW == 32 || DW == 64)) begin : g_bad_dw
         $error("dma_wconv_engine: DW must be 32 or 64");
      end
      if (AW < 8) begin : g_bad_aw
         $error("dma_wconv_engine: AW must be at least 8");
      end
      if (CW < 1) begin : g_bad_cw
         $error("dma_wconv_engine: CW must be at least 1");
      end
   endgenerate

   wid_e          src_wid_q;
   wid_e          dst_wid_q;
   logic          src_inc_q;
   logic          dst_inc_q;
   logic          src_step4_q;
   logic          load;
   logic          push;
   logic          pop;
   logic [FW-1:0] fill;
   logic [2:0]    src_bytes;
   logic [2:0]    dst_bytes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_wid_q   <= WID_B8;
         dst_wid_q   <= WID_B8;
         src_inc_q   <= 1'b0;
         dst_inc_q   <= 1'b0;
         src_step4_q <= 1'b0;
      end else if (load) begin
         src_wid_q   <= wid_norm(cfg_src_wid);
         dst_wid_q   <= wid_norm(cfg_dst_wid);
         src_inc_q   <= cfg_src_inc;
         dst_inc_q   <= cfg_dst_inc;
         src_step4_q <= cfg_src_step4;
      end
   end

   assign src_bytes = wid_bytes(src_wid_q);
   assign dst_bytes = wid_bytes(dst_wid_q);
   assign src_size  = src_wid_q;
   assign dst_size  = dst_wid_q;

   dma_wconv_seq #(.CW(CW), .FW(FW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .items      (cfg_items),
      .fill       (fill),
      .word_bytes (FW'(dst_bytes)),
      .rd_valid   (src_valid),
      .wr_ack     (dst_ack),
      .load       (load),
      .rd_req     (src_req),
      .wr_req     (dst_req),
      .push       (push),
      .pop        (pop),
      .busy       (busy),
      .done       (done)
   );

   dma_wconv_pack_buf #(.DW(DW)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (load),
      .push       (push),
      .push_data  (src_data),
      .push_bytes (FW'(src_bytes)),
      .pop        (pop),
      .pop_bytes  (FW'(dst_bytes)),
      .fill       (fill),
      .head       (dst_data)
   );

   dma_wconv_addr_gen #(.AW(AW), .WORD_STEP_OK(1'b1)) u_src_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .base       (cfg_src_base),
      .inc_en     (src_inc_q),
      .word_step  (src_step4_q),
      .unit_bytes (src_bytes),
      .advance    (push),
      .addr       (src_addr)
   );

   dma_wconv_addr_gen #(.AW(AW), .WORD_STEP_OK(1'b0)) u_dst_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .base       (cfg_dst_base),
      .inc_en     (dst_inc_q),
      .word_step  (1'b0),
      .unit_bytes (dst_bytes),
      .advance    (pop),
      .addr       (dst_addr)
   );

endmodule

// File: rtl/dma_wconv_engine_chk.sv
module dma_wconv_engine_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          src_req,
   input logic          src_valid,
   input logic [AW-1:0] src_addr,
   input logic [1:0]    src_size,
   input logic          dst_req,
   input logic          dst_ack,
   input logic [AW-1:0] dst_addr,
   input logic [1:0]    dst_size,
   input logic [DW-1:0] dst_data
);

   a_r10_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (src_req && !src_valid) |=> (src_req && $stable(src_addr)));

   a_r10_dst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_req && !dst_ack) |=> (dst_req && $stable(dst_addr) && $stable(dst_data)));

   a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n)
      !(src_req && dst_req));

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!src_req && !dst_req));

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   a_r9_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!src_req && !dst_req));

   a_r1_src_size: assert property (@(posedge clk) disable iff (!rst_n)
      src_req |-> (src_size != 2'b11));

   a_r1_dst_size: assert property (@(posedge clk) disable iff (!rst_n)
      dst_req |-> (dst_size != 2'b11));

   a_r8_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_req && dst_size == 2'b00) |-> (dst_data[DW-1:8] == '0));

   a_r8_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_req && dst_size == 2'b01) |-> (dst_data[DW-1:16] == '0));

endmodule

bind dma_wconv_engine dma_wconv_engine_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .src_req   (src_req),
   .src_valid (src_valid),
   .src_addr  (src_addr),
   .src_size  (src_size),
   .dst_req   (dst_req),
   .dst_ack   (dst_ack),
   .dst_addr  (dst_addr),
   .dst_size  (dst_size),
   .dst_data  (dst_data)
);

// File: tb/dma_wconv_engine_test.sv
`timescale 1ns/1ps
module dma_wconv_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  cfg_src_wid = '0, cfg_dst_wid = '0;
   logic        cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0, cfg_src_step4 = 1'b0;
   logic [15:0] cfg_items = '0;
   logic [31:0] cfg_src_base = '0, cfg_dst_base = '0;
   logic        src_req, dst_req, busy, done;
   logic [31:0] src_addr, dst_addr, dst_data;
   logic [1:0]  src_size, dst_size;
   logic        src_valid = 1'b0, dst_ack = 1'b0;
   logic [31:0] src_data = '0;

   always #2 clk = ~clk;

   dma_wconv_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_src_wid(cfg_src_wid), .cfg_dst_wid(cfg_dst_wid),
      .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
      .cfg_src_step4(cfg_src_step4), .cfg_items(cfg_items),
      .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
      .src_req(src_req), .src_addr(src_addr), .src_size(src_size),
      .src_valid(src_valid), .src_data(src_data),
      .dst_req(dst_req), .dst_addr(dst_addr), .dst_size(dst_size),
      .dst_data(dst_data), .dst_ack(dst_ack),
      .busy(busy), .done(done)
   );

   int n_chk = 0, n_bad = 0;
   int cyc = 0;

   logic [31:0] exp_raddr [0:31];
   logic [31:0] exp_waddr [0:31];
   logic [31:0] exp_wdata [0:31];
   int exp_nr, exp_nw, exp_total;
   int got_r, got_w, rd_bytes, wr_bytes;
   int cur_pb, cur_mb, cur_pw, cur_mw;
   int rwait = 0, rlat = 0, wwait = 0, wlat = 1;
   bit pend_done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pbyte(input logic [31:0] a);
      return a[7:0] * 8'd29 + a[15:8] + 8'h5B;
   endfunction

   function automatic logic [31:0] pword(input logic [31:0] a);
      return {pbyte(a + 3), pbyte(a + 2), pbyte(a + 1), pbyte(a)};
   endfunction

   // responders and per-handshake checks, all on the falling edge
   always @(negedge clk) begin
      if (pend_done) begin
         chk(done == 1'b1, "R9 done one cycle after last ack", 32'(done), 32'd1);
         pend_done = 1'b0;
      end
      if (src_req && !src_valid) begin
         if (rwait >= rlat) begin
            chk(got_r < exp_nr, "R2 read count", got_r, exp_nr);
            chk(src_addr == exp_raddr[got_r & 31], "R6 source address", src_addr, exp_raddr[got_r & 31]);
            chk(src_size == 2'(cur_pw), "R1 source size", 32'(src_size), cur_pw);
            if (cur_pb >= cur_mb)
               chk(wr_bytes == rd_bytes, "R4 read waits for pieces", wr_bytes, rd_bytes);
            src_valid = 1'b1;
            src_data  = pword(src_addr);
            got_r++;
            rd_bytes += cur_pb;
            rlat  = (rlat + 1) % 3;
            rwait = 0;
         end else rwait++;
      end else if (!src_req) src_valid = 1'b0;

      if (dst_req && !dst_ack) begin
         if (wwait >= wlat) begin
            string tg;
            bit last;
            last = (got_w == exp_nw - 1);
            if (last && (exp_total % cur_mb) != 0) tg = "R8 padded word";
            else if (cur_pb < cur_mb) tg = "R3 packed word";
            else if (cur_pb > cur_mb) tg = "R4 unpacked piece";
            else tg = "R5 passthrough";
            chk(got_w < exp_nw, "R2 write count", got_w, exp_nw);
            chk(dst_addr == exp_waddr[got_w & 31], "R7 destination address", dst_addr, exp_waddr[got_w & 31]);
            chk(dst_data == exp_wdata[got_w & 31], tg, dst_data, exp_wdata[got_w & 31]);
            chk(dst_size == 2'(cur_mw), "R1 destination size", 32'(dst_size), cur_mw);
            chk((rd_bytes >= (got_w + 1) * cur_mb) || (last && got_r == exp_nr),
                "R3 full word before write", rd_bytes, (got_w + 1) * cur_mb);
            dst_ack = 1'b1;
            got_w++;
            wr_bytes += cur_mb;
            if (got_w == exp_nw) pend_done = 1'b1;
            wlat  = (wlat + 1) % 3;
            wwait = 0;
         end else wwait++;
      end else if (!dst_req) dst_ack = 1'b0;
   end

   task automatic run_job(input int pw, input int mw, input bit pinc, input bit minc,
                          input bit p4, input int cnt);
      logic [7:0]  eb [0:31];
      logic [31:0] pbase, mbase, a, d;
      int t;
      pbase = 32'h4000_1000 + 32'(pw * 16);
      mbase = 32'h2000_0200 + 32'(mw * 64);
      cur_pw = pw; cur_mw = mw;
      cur_pb = 1 << pw; cur_mb = 1 << mw;
      exp_nr = cnt;
      exp_total = cnt * cur_pb;
      for (int i = 0; i < cnt; i++) begin
         a = pbase + (pinc ? 32'(i * (p4 ? 4 : cur_pb)) : 32'd0);
         exp_raddr[i] = a;
         for (int k = 0; k < cur_pb; k++) eb[i * cur_pb + k] = pbyte(a + 32'(k));
      end
      exp_nw = (exp_total + cur_mb - 1) / cur_mb;
      for (int j = 0; j < exp_nw; j++) begin
         exp_waddr[j] = mbase + (minc ? 32'(j * cur_mb) : 32'd0);
         d = '0;
         for (int k = 0; k < cur_mb; k++)
            if (j * cur_mb + k < exp_total) d |= 32'(eb[j * cur_mb + k]) << (8 * k);
         exp_wdata[j] = d;
      end
      got_r = 0; got_w = 0; rd_bytes = 0; wr_bytes = 0;

      @(negedge clk);
      cfg_src_wid = 2'(pw); cfg_dst_wid = 2'(mw);
      cfg_src_inc = pinc; cfg_dst_inc = minc; cfg_src_step4 = p4;
      cfg_items = 16'(cnt); cfg_src_base = pbase; cfg_dst_base = mbase;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R11: scramble the configuration after capture
      cfg_src_wid = 2'(2 - pw); cfg_dst_wid = 2'(2 - mw);
      cfg_src_inc = ~pinc; cfg_dst_inc = ~minc; cfg_src_step4 = ~p4;
      cfg_items = 16'd9; cfg_src_base = 32'h0BAD_0000; cfg_dst_base = 32'h0BAD_1000;
      if (cnt > 0) begin
         @(negedge clk);
         start = 1'b1;   // R11: restart attempt while busy
         @(negedge clk);
         start = 1'b0;
      end
      t = 0;
      while (!done && t < 400) begin
         @(negedge clk);
         t++;
      end
      chk(t < 400, "R9 done reached", t, 400);
      chk(got_r == exp_nr, "R2 total reads", got_r, exp_nr);
      chk(got_w == exp_nw, "R2/R11 total writes", got_w, exp_nw);
      @(negedge clk);
      chk(!done && !busy, "R9 done single and idle after", {done, busy}, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!src_req && !dst_req, "R10 quiet after reset", {src_req, dst_req}, 0);
      chk(!busy && !done, "R9 idle after reset", {busy, done}, 0);

      // zero-item job
      run_job(0, 2, 1'b1, 1'b1, 1'b0, 0);
      chk(got_r == 0 && got_w == 0, "R9 empty job has no transfers", got_r + got_w, 0);

      for (int pw = 0; pw < 3; pw++)
         for (int mw = 0; mw < 3; mw++)
            for (int mode = 0; mode < 4; mode++)
               foreach (cnts[ci])
                  run_job(pw, mw, mode != 2, mode != 3, mode == 1, cnts[ci]);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   int cnts [5] = '{1, 2, 3, 5, 8};

endmodule